// File: doc/BRIEF.md
# Record-Path Overload Flag and Start-Up Output Mute

This block sits after the decimation stage of a stereo recording path and sees one signed left/right sample pair per sample period, marked by a valid strobe. It raises a registered overload indication whenever either channel comes within roughly 1.16 dB of digital full scale. Once raised, the indication is held for a fixed minimum number of sample periods, and each fresh excursion restarts that hold. It also forces the outgoing samples to zero for a settling interval after reset or after a restart pulse. That interval is longer when the DC-removal high-pass filter upstream is enabled, because that filter needs more time to settle.

All time is counted in valid sample strobes, never in clock cycles, so the block is insensitive to how the strobes are spaced. While the output is muted, the overload detector is held off so that settling transients cannot raise the indication.

Top module: `adc_overload_mute`

## Requirements
- R1: Out of reset, `ovl_flag`, `out_valid`, `out_left` and `out_right` are all 0, and the output is muted.
- R2: With `dc_cancel_en` = 0, the first 1024 valid sample pairs after reset or restart leave the block as zeros, and the 1025th passes unchanged.
- R3: With `dc_cancel_en` = 1, the mute spans the first 12288 valid sample pairs after reset or restart.
- R4: The mute count advances only on cycles where `in_valid` = 1; idle cycles do not shorten the mute.
- R5: A sample trips the detector exactly when its 20-bit two's-complement value x satisfies |x| > 458752. So 458752 and -458752 do not trip, 458753 and -458753 do, and -524288 does.
- R6: A trip on the left channel alone or on the right channel alone raises the flag.
- R7: `ovl_flag` rises on the clock edge that captures the tripping strobe, so it is visible one cycle after that strobe is presented.
- R8: After the last trip, `ovl_flag` stays high through the next 511 non-tripping valid samples and falls with the 512th.
- R9: A trip while the flag is already high restarts the full 512-sample hold.
- R10: While muted, samples never raise the flag, and any hold in progress is cleared.
- R11: `restart` clears the mute and hold counters on the next edge and clears the flag. A sample presented in the same cycle as `restart` leaves the block as zero and is not counted.
- R12: `out_valid` is `in_valid` delayed by one clock. `out_left` and `out_right` change only on edges where `in_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | One-cycle pulse that restarts the mute and clears the hold |
| dc_cancel_en | input | 1 | 1 selects the long mute (DC-removal filter active) |
| in_valid | input | 1 | Sample-pair strobe |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_left | output | 20 | Left sample, or zero while muted |
| out_right | output | 20 | Right sample, or zero while muted |
| ovl_flag | output | 1 | Registered overload indication |

## Verification
The bench targets the exact threshold codes on both sides and both signs, including the most negative code. A design using >= instead of >, or negating -524288 without widening, would report the wrong trip there. It times both mute lengths to the exact sample while inserting idle gaps, which exposes a counter off by one or one that counts clocks. It drives hold expiry at exactly 512 samples, a right-only retrigger in mid-hold, and a restart that coincides with a sample. These catch a hold that is one short or long, a retrigger that does not reload, and a restart that leaks a sample or leaves the flag high.

// File: rtl/adcg_pkg.sv
package adcg_pkg;

  // True when a sign-extended sample lies strictly beyond +/-limit.
  function automatic logic beyond_limit(input int sample, input int limit);
    return (sample > limit) || (sample < -limit);
  endfunction

  // Selected mute length for the current filter configuration.
  function automatic int mute_span(input logic dc_on, input int short_len, input int long_len);
    return dc_on ? long_len : short_len;
  endfunction

endpackage

// File: rtl/adcg_level_check.sv
module adcg_level_check #(
  parameter int SAMPLE_W = 20,
  parameter int CHANNELS = 2
) (
  input  logic [CHANNELS*SAMPLE_W-1:0] samples,
  output logic [CHANNELS-1:0]          over
);
  import adcg_pkg::*;

  localparam int FULL_SCALE = 1 << (SAMPLE_W - 1);
  localparam int THRESH     = (FULL_SCALE / 8) * 7;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic signed [SAMPLE_W-1:0] chan_s;
    assign chan_s  = signed'(samples[g*SAMPLE_W +: SAMPLE_W]);
    assign over[g] = beyond_limit(int'(chan_s), THRESH);
  end

endmodule

// File: rtl/adcg_mute_timer.sv
module adcg_mute_timer #(
  parameter int SHORT_LEN = 1024,
  parameter int LONG_LEN  = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic dc_cancel_en,
  input  logic sample_strobe,
  output logic muted
);
  import adcg_pkg::*;

  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] mute_cnt;
  logic [CW-1:0] limit;
  logic          advance;

  assign limit   = CW'(mute_span(dc_cancel_en, SHORT_LEN, LONG_LEN));
  assign muted   = mute_cnt < limit;
  assign advance = sample_strobe && muted && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       mute_cnt <= '0;
    else if (restart) mute_cnt <= '0;
    else if (advance) mute_cnt <= mute_cnt + 1'b1;
  end

  a_r11_restart_clears_mute: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mute_cnt == '0));

  a_r4_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && !restart) |=> $stable(mute_cnt));

endmodule

// File: rtl/adcg_overload_hold.sv
module adcg_overload_hold #(
  parameter int HOLD_SAMPLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample_strobe,
  input  logic trip,
  output logic flag
);
  localparam int HW = $clog2(HOLD_SAMPLES + 1);

  logic [HW-1:0] hold_cnt;
  logic [HW-1:0] hold_nxt;

  always_comb begin
    hold_nxt = hold_cnt;
    if (clear)                                hold_nxt = '0;
    else if (trip)                            hold_nxt = HW'(HOLD_SAMPLES);
    else if (sample_strobe && hold_cnt != '0) hold_nxt = hold_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      flag     <= 1'b0;
    end else begin
      hold_cnt <= hold_nxt;
      flag     <= (hold_nxt != '0);
    end
  end

  a_r7_trip_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clear) |=> flag);

  a_r9_trip_reloads_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clear) |=> (hold_cnt == HW'(HOLD_SAMPLES)));

  a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !flag);

  a_r8_hold_steady_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && !clear && !trip) |=> ($stable(hold_cnt) && $stable(flag)));

endmodule

// File: rtl/adc_overload_mute.sv
module adc_overload_mute #(
  parameter int SAMPLE_W     = 20,
  parameter int HOLD_SAMPLES = 512,
  parameter int MUTE_SHORT   = 1024,
  parameter int MUTE_LONG    = 12288
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       dc_cancel_en,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       ovl_flag
);
  localparam int CHANNELS = 2;

  logic [CHANNELS-1:0] chan_over;
  logic                muted;
  logic                gate_zero;
  logic                trip_evt;
  logic                hold_clear;

  adcg_level_check #(.SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS)) u_level (
    .samples ({in_right, in_left}),
    .over    (chan_over)
  );

  adcg_mute_timer #(.SHORT_LEN(MUTE_SHORT), .LONG_LEN(MUTE_LONG)) u_mute (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .dc_cancel_en  (dc_cancel_en),
    .sample_strobe (in_valid),
    .muted         (muted)
  );

  assign gate_zero  = muted || restart;
  assign hold_clear = gate_zero;
  assign trip_evt   = in_valid && !gate_zero && (|chan_over);

  adcg_overload_hold #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (hold_clear),
    .sample_strobe (in_valid),
    .trip          (trip_evt),
    .flag          (ovl_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= gate_zero ? '0 : in_left;
        out_right <= gate_zero ? '0 : in_right;
      end
    end
  end

  a_r2_muted_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gate_zero) |=> (out_left == '0 && out_right == '0));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r12_idle_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

  a_r10_no_flag_while_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_zero && !$past(gate_zero)) |=> !ovl_flag);

endmodule

// File: tb/adc_overload_mute_test.sv
module adc_overload_mute_test;

  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic dc_cancel_en = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_left = '0;
  logic signed [W-1:0] in_right = '0;
  logic out_valid;
  logic signed [W-1:0] out_left;
  logic signed [W-1:0] out_right;
  logic ovl_flag;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  int m_hold = 0;

  always #5 clk = ~clk;

  adc_overload_mute uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .dc_cancel_en(dc_cancel_en),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .ovl_flag(ovl_flag)
  );

  function automatic bit trips(input int v);
    int mag;
    mag = (v < 0) ? -v : v;
    return mag > 458752;
  endfunction

  function automatic int mute_len();
    return dc_cancel_en ? 12288 : 1024;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Present one sample pair (optionally together with restart) and check.
  task automatic send(input int l, input int r, input bit rs, input string req);
    int exp_l, exp_r;
    bit m;
    @(negedge clk);
    in_valid = 1'b1; in_left = W'(l); in_right = W'(r); restart = rs;
    if (rs) begin
      m_cnt = 0; m_hold = 0; exp_l = 0; exp_r = 0;
    end else begin
      m = m_cnt < mute_len();
      exp_l = m ? 0 : l;
      exp_r = m ? 0 : r;
      if (m) begin
        m_cnt++; m_hold = 0;
      end else if (trips(l) || trips(r)) m_hold = 512;
      else if (m_hold > 0) m_hold--;
    end
    @(negedge clk);
    in_valid = 1'b0; restart = 1'b0;
    check({req, " out_left"},  int'(out_left),  exp_l);
    check({req, " out_right"}, int'(out_right), exp_r);
    check({req, " ovl_flag"},  int'(ovl_flag),  (m_hold != 0) ? 1 : 0);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({req, " out_valid idle"}, int'(out_valid), 0);
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1;
    m_cnt = 0; m_hold = 0;
    @(negedge clk);
    restart = 1'b0;
    check("R11 flag after restart", int'(ovl_flag), 0);
  endtask

  function automatic int small_val();
    return int'($urandom_range(800000)) - 400000;
  endfunction

  function automatic int big_val();
    return ($urandom_range(1) != 0) ? 500000 : -500000;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ovl_flag", int'(ovl_flag), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_left", int'(out_left), 0);
    check("R1 out_right", int'(out_right), 0);
    rst_n = 1'b1;

    // R2, R4, R10: short mute with idle gaps, loud input must not trip
    for (int i = 0; i < 1024; i++) begin
      send(big_val(), big_val(), 1'b0, "R2 R10 short mute");
      if (i % 7 == 0) idle(int'($urandom_range(3)), "R4 R12");
    end
    // first unmuted sample trips (R2 boundary, R7 timing)
    send(500000, 3, 1'b0, "R2 R7 first live sample");

    // R8: hold expiry exactly at 512
    for (int i = 0; i < 512; i++) send(small_val(), small_val(), 1'b0, "R8 hold");
    check("R8 flag low after 512", int'(ovl_flag), 0);

    // R6 + R9: left trip, then right-only retrigger mid-hold
    send(-470000, 0, 1'b0, "R6 left only");
    for (int i = 0; i < 300; i++) send(small_val(), small_val(), 1'b0, "R9 pre-retrigger");
    send(0, 490000, 1'b0, "R6 R9 right only retrigger");
    for (int i = 0; i < 512; i++) send(small_val(), small_val(), 1'b0, "R9 full reload");

    // R5: exact threshold codes
    send(458752, -458752, 1'b0, "R5 at threshold");
    send(-458752, 458752, 1'b0, "R5 at threshold swapped");
    send(458753, 0, 1'b0, "R5 just above");
    for (int i = 0; i < 512; i++) send(1, -1, 1'b0, "R5 drain");
    send(0, -458753, 1'b0, "R5 just below negative");
    for (int i = 0; i < 512; i++) send(2, 2, 1'b0, "R5 drain");
    send(-524288, 0, 1'b0, "R5 most negative");
    for (int i = 0; i < 100; i++) send(small_val(), small_val(), 1'b0, "R5 hold");

    // R11: restart coinciding with a sample while the flag is high
    send(0, -524288, 1'b1, "R11 restart with sample");
    for (int i = 0; i < 1024; i++) send(big_val(), small_val(), 1'b0, "R11 R2 re-mute");
    send(7, -9, 1'b0, "R11 R2 live after restart");

    // R3: long mute with the DC filter enabled
    dc_cancel_en = 1'b1;
    pulse_restart();
    for (int i = 0; i < 12288; i++) begin
      send(big_val(), big_val(), 1'b0, "R3 R10 long mute");
      if (i % 97 == 0) idle(1, "R4 R12");
    end
    send(123, 500000, 1'b0, "R3 R7 first live long");
    send(small_val(), small_val(), 1'b0, "R8 post long");

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(40) == 0) send(big_val(), small_val(), 1'b0, "R5 R9 random");
      else send(small_val(), small_val(), 1'b0, "R8 random");
      if ($urandom_range(5) == 0) idle(1, "R12 random");
    end

    finish_run();
  end

endmodule